// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block sits between a memory request source and the command interface of a DRAM device. Each request names an operation (read or write), a bank, a row, a column and a tag. Requests enter a 4-entry in-order queue. The sequencer takes them one at a time from the head of the queue and turns each one into a short run of device commands. It keeps a record, per bank, of whether the bank is closed or which row it holds open. From that record it chooses between three paths:

- a direct data command, when the request hits the open row;
- an activate followed by the data command, when the bank is closed;
- a precharge, an activate and then the data command, when the bank holds another row open.

Every command is followed by a fixed latency before the next step can start. Any two precharges are held at least a minimum number of cycles apart. A refresh timer raises a request a set number of times in each refresh window. The refresh is taken only between requests: a precharge of all banks, then a refresh command, after which every bank is closed. When the read or write latency of a request expires, the block emits a single-cycle completion pulse that carries the request's tag.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, no command and no completion are output, `req_ready` is 1, and every bank is closed, so the first request to any bank begins with an activate.
- R2: A request to a closed bank issues ACTIVATE (code 1) with the request's bank and row one cycle after acceptance (when idle). It then issues the data command `T_ACT` (8) cycles later.
- R3: A request whose row is already open in its bank issues READ (code 2) or WRITE (code 3) directly, one cycle after acceptance when idle, with no activate.
- R4: A request to a bank that holds a different row issues PRECHARGE (code 4) for that bank, then ACTIVATE `T_PRE` (8) cycles later, then the data command `T_ACT` (8) cycles after that.
- R5: Any two precharges, whether single-bank (code 4) or all-bank (code 5), are at least `T_PGAP` (34) cycles apart. A precharge that is due earlier waits until the gap has elapsed.
- R6: `done_valid` pulses for one cycle exactly `T_RD` (4) cycles after a READ, or `T_WR` (4) cycles after a WRITE, with `done_tag` equal to the tag of that request. No command is issued in that cycle.
- R7: The queue holds 4 requests and serves them in order. `req_ready` is 0 while 4 requests are held, and completions appear in acceptance order.
- R8: Refresh is requested every `REF_WINDOW/REF_COUNT` cycles. It runs as PRECHARGE-ALL (code 5), then REFRESH (code 6) `T_PRE` cycles later. No further command is issued until `T_REF` (64) cycles after the REFRESH.
- R9: A refresh is inserted only while no request is in progress. After it, every bank is closed, so a request to a previously open row begins with ACTIVATE.
- R10: Banks are independent: opening or closing a row in one bank leaves the open row of every other bank in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_tag | input | TAG_W | Request tag returned on completion |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_code | output | 3 | 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PRE-all, 6 REF, 0 none |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row, meaningful for ACT |
| cmd_col | output | COL_W | Column, meaningful for RD/WR |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |

## Verification
A corrupted open-row record shows up at the command port within the next request to the affected bank. A hit that should be direct gains an activate, or a miss skips its precharge. The first command cycle then moves by 8 or 16 cycles, and the bench sees this right away. A wrong precharge-gap count or a stale refresh state appears as a precharge issued too early, or as an activate missing after a refresh. Both are visible at the first precharge or at the first request that follows the refresh. A lost queue pointer shows up as a completion with the wrong tag or in the wrong order, at the very next completion.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ACT, S_DATA, S_DONE, S_PREA, S_REF
  } seq_st_e;

  function automatic int data_lat(input logic wr, input int trd, input int twr);
    return wr ? twr : trd;
  endfunction

  function automatic int ref_period(input int window, input int count);
    return window / count;
  endfunction
endpackage

// File: rtl/dseq_refq.sv
module dseq_refq #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_p, wr_p;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_p];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p  <= '0;
      wr_p  <= '0;
      count <= '0;
    end else begin
      if (push && !full) wr_p <= step(wr_p);
      if (pop && !empty) rd_p <= step(rd_p);
      count <= count + CW'(push && !full) - CW'(pop && !empty);
    end
  end
endmodule

// File: rtl/dseq_bank_tbl.sv
module dseq_bank_tbl #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 14,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_en,
  input  logic              pre_en,
  input  logic              all_close,
  input  logic [BANK_W-1:0] sel_bank,
  input  logic [ROW_W-1:0]  act_row,
  output logic [BANKS-1:0]  open_mask,
  output logic [ROW_W-1:0]  open_row [BANKS]
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic mine;
    assign mine = (sel_bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_mask[b] <= 1'b0;
        open_row[b]  <= '0;
      end else if (all_close || (pre_en && mine)) begin
        open_mask[b] <= 1'b0;
      end else if (act_en && mine) begin
        open_mask[b] <= 1'b1;
        open_row[b]  <= act_row;
      end
    end
  end
endmodule

// File: rtl/dseq_pre_gap.sv
module dseq_pre_gap #(
  parameter int GAP = 34,
  localparam int GW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_fire,
  output logic ok
);
  logic [GW-1:0] since;
  assign ok = (since == GW'(GAP));
  always_ff @(posedge clk) begin
    if (!rst_n)                 since <= GW'(GAP);
    else if (pre_fire)          since <= GW'(1);
    else if (since != GW'(GAP)) since <= since + 1'b1;
  end
endmodule

// File: rtl/dseq_ref_timer.sv
module dseq_ref_timer #(
  parameter int PERIOD = 390,
  localparam int TW    = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic pend
);
  logic [TW-1:0] cnt;
  logic          tick;
  assign tick = (cnt == '0);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= TW'(PERIOD - 1);
      pend <= 1'b0;
    end else begin
      cnt  <= tick ? TW'(PERIOD - 1) : cnt - 1'b1;
      pend <= (pend && !served) || tick;
    end
  end
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dseq_pkg::*;
#(
  parameter int BANKS      = 4,
  parameter int ROW_W      = 14,
  parameter int COL_W      = 10,
  parameter int TAG_W      = 4,
  parameter int QDEPTH     = 4,
  parameter int T_ACT      = 8,
  parameter int T_PRE      = 8,
  parameter int T_RD       = 4,
  parameter int T_WR       = 4,
  parameter int T_REF      = 64,
  parameter int T_PGAP     = 34,
  parameter int REF_WINDOW = 3120,
  parameter int REF_COUNT  = 8,
  localparam int BANK_W    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag
);
  localparam int ENT_W  = 1 + BANK_W + ROW_W + COL_W + TAG_W;
  localparam int QC_W   = $clog2(QDEPTH + 1);
  localparam int CNT_W  = $clog2(T_ACT + T_PRE + T_RD + T_WR + T_REF + 2);
  localparam int PERIOD = ref_period(REF_WINDOW, REF_COUNT);

  // queue
  logic [ENT_W-1:0]  q_dout;
  logic              q_empty, q_full, q_pop;
  logic [QC_W-1:0]   q_count;
  logic              h_wr;
  logic [BANK_W-1:0] h_bank;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic [TAG_W-1:0]  h_tag;

  dseq_refq #(.W(ENT_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(req_valid && req_ready), .pop(q_pop),
    .din({req_wr, req_bank, req_row, req_col, req_tag}),
    .dout(q_dout), .empty(q_empty), .full(q_full), .count(q_count)
  );
  assign req_ready = !q_full;
  assign {h_wr, h_bank, h_row, h_col, h_tag} = q_dout;

  // named internal events
  cmd_e             cmd;
  logic             pre_fire, ref_served, pre_ok, ref_pend;
  logic [BANKS-1:0] open_mask;
  logic [ROW_W-1:0] open_row [BANKS];
  logic             tgt_open, tgt_hit;

  dseq_bank_tbl #(.BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(cmd == CMD_ACT), .pre_en(cmd == CMD_PRE), .all_close(cmd == CMD_PREA),
    .sel_bank(h_bank), .act_row(h_row),
    .open_mask(open_mask), .open_row(open_row)
  );

  assign pre_fire   = (cmd == CMD_PRE) || (cmd == CMD_PREA);
  assign ref_served = (cmd == CMD_REF);

  dseq_pre_gap #(.GAP(T_PGAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .pre_fire(pre_fire), .ok(pre_ok)
  );

  dseq_ref_timer #(.PERIOD(PERIOD)) u_ref (
    .clk(clk), .rst_n(rst_n), .served(ref_served), .pend(ref_pend)
  );

  assign tgt_open = open_mask[h_bank];
  assign tgt_hit  = tgt_open && (open_row[h_bank] == h_row);

  // sequencing
  seq_st_e          st, nxt_st;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic [CNT_W-1:0] data_wait;
  cmd_e             data_cmd;

  assign data_wait = CNT_W'(data_lat(h_wr, T_RD, T_WR) - 1);
  assign data_cmd  = h_wr ? CMD_WR : CMD_RD;

  always_comb begin
    cmd        = CMD_NOP;
    nxt_st     = st;
    nxt_cnt    = cnt;
    q_pop      = 1'b0;
    done_valid = 1'b0;
    if (cnt != '0) begin
      nxt_cnt = cnt - 1'b1;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (ref_pend) begin
            if (pre_ok) begin
              cmd = CMD_PREA; nxt_cnt = CNT_W'(T_PRE - 1); nxt_st = S_REF;
            end else nxt_st = S_PREA;
          end else if (!q_empty) begin
            if (tgt_hit) begin
              cmd = data_cmd; nxt_cnt = data_wait; nxt_st = S_DONE;
            end else if (!tgt_open) begin
              cmd = CMD_ACT; nxt_cnt = CNT_W'(T_ACT - 1); nxt_st = S_DATA;
            end else if (pre_ok) begin
              cmd = CMD_PRE; nxt_cnt = CNT_W'(T_PRE - 1); nxt_st = S_ACT;
            end else nxt_st = S_PRE;
          end
        end
        S_PRE: if (pre_ok) begin
          cmd = CMD_PRE; nxt_cnt = CNT_W'(T_PRE - 1); nxt_st = S_ACT;
        end
        S_ACT: begin
          cmd = CMD_ACT; nxt_cnt = CNT_W'(T_ACT - 1); nxt_st = S_DATA;
        end
        S_DATA: begin
          cmd = data_cmd; nxt_cnt = data_wait; nxt_st = S_DONE;
        end
        S_DONE: begin
          q_pop = 1'b1; done_valid = 1'b1; nxt_st = S_IDLE;
        end
        S_PREA: if (pre_ok) begin
          cmd = CMD_PREA; nxt_cnt = CNT_W'(T_PRE - 1); nxt_st = S_REF;
        end
        S_REF: begin
          cmd = CMD_REF; nxt_cnt = CNT_W'(T_REF - 1); nxt_st = S_IDLE;
        end
        default: nxt_st = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= nxt_st;
      cnt <= nxt_cnt;
    end
  end

  logic all_bank_cmd;
  assign all_bank_cmd = (cmd == CMD_PREA) || (cmd == CMD_REF);
  assign cmd_valid    = (cmd != CMD_NOP);
  assign cmd_code     = cmd;
  assign cmd_bank     = (cmd_valid && !all_bank_cmd) ? h_bank : '0;
  assign cmd_row      = (cmd == CMD_ACT) ? h_row : '0;
  assign cmd_col      = (cmd == CMD_RD || cmd == CMD_WR) ? h_col : '0;
  assign done_tag     = done_valid ? h_tag : '0;
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
  parameter int BANKS  = 4,
  parameter int QDEPTH = 4,
  parameter int T_PGAP = 34,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int QC_W   = $clog2(QDEPTH + 1),
  localparam int GW     = $clog2(T_PGAP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              done_valid,
  input logic [BANKS-1:0]  open_mask,
  input logic              ref_pend,
  input logic [QC_W-1:0]   q_count
);
  logic          is_pre;
  logic [GW-1:0] gap_cnt;
  assign is_pre = cmd_valid && (cmd_code == 3'd4 || cmd_code == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n)                   gap_cnt <= GW'(T_PGAP);
    else if (is_pre)              gap_cnt <= GW'(1);
    else if (gap_cnt != GW'(T_PGAP)) gap_cnt <= gap_cnt + 1'b1;
  end

  assert_prech_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> gap_cnt >= GW'(T_PGAP));

  assert_act_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd1) |-> !open_mask[cmd_bank]);

  assert_act_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd1) |=> !cmd_valid);

  assert_data_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == 3'd2 || cmd_code == 3'd3)) |-> open_mask[cmd_bank]);

  assert_ref_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd6) |-> (open_mask == '0));

  assert_ref_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd5) |-> ref_pend);

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !cmd_valid);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QC_W'(QDEPTH));
endmodule

bind dram_cmd_seq dseq_checker #(.BANKS(BANKS), .QDEPTH(QDEPTH), .T_PGAP(T_PGAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .done_valid(done_valid), .open_mask(open_mask),
  .ref_pend(ref_pend), .q_count(q_count)
);

// File: tb/test_dram_cmd_seq.sv
`timescale 1ns/1ps
module test_dram_cmd_seq;
  localparam int BANKS = 4, ROW_W = 8, COL_W = 6, TAG_W = 4;
  localparam int PERIOD = 2000, TPG = 34;
  localparam int C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_PREA = 5, C_REF = 6;
  localparam int VW = 1 + 2 + ROW_W + COL_W + TAG_W;

  function automatic logic [VW-1:0] mk(int wr, int b, int r, int c, int t);
    return {wr[0], b[1:0], r[ROW_W-1:0], c[COL_W-1:0], t[TAG_W-1:0]};
  endfunction

  // op, bank, row, col, tag
  localparam logic [VW-1:0] VEC [10] = '{
    mk(0, 0, 5, 1, 1),  mk(0, 0, 5, 2, 2),  mk(1, 1, 7, 3, 3),  mk(0, 0, 5, 4, 4),
    mk(1, 0, 9, 5, 5),  mk(0, 0, 5, 6, 6),  mk(1, 1, 7, 7, 7),  mk(0, 1, 2, 8, 8),
    mk(1, 3, 0, 9, 9),  mk(0, 2, 1, 10, 10)
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wr = 0, req_ready;
  logic [1:0] req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic [TAG_W-1:0] req_tag = 0;
  logic cmd_valid, done_valid;
  logic [2:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [TAG_W-1:0] done_tag;

  dram_cmd_seq #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
                 .REF_WINDOW(4000), .REF_COUNT(2)) i_dram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_tag(req_tag), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;

  // port monitor
  int n_log = 0, n_done = 0, n_ref = 0, n_prea = 0;
  int lg_code [64]; int lg_cyc [64]; int lg_bank [64]; int lg_row [64]; int lg_col [64];
  int dn_cyc [16]; int dn_tag [16];
  int ref_at [4]; int prea_at [4];

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid && n_log < 64) begin
      lg_code[n_log] = cmd_code; lg_cyc[n_log] = cyc; lg_bank[n_log] = cmd_bank;
      lg_row[n_log] = cmd_row; lg_col[n_log] = cmd_col; n_log++;
    end
    if (cmd_valid && cmd_code == 3'(C_REF) && n_ref < 4) begin ref_at[n_ref] = cyc; n_ref++; end
    if (cmd_valid && cmd_code == 3'(C_PREA) && n_prea < 4) begin prea_at[n_prea] = cyc; n_prea++; end
    if (done_valid && n_done < 16) begin
      dn_cyc[n_done] = cyc; dn_tag[n_done] = done_tag; n_done++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // bench's own model of the bank rows and precharge history
  bit bopen [4]; int brow [4];
  int lastpre = -1000;

  task automatic run_ref(input logic [VW-1:0] v, input int earliest);
    int k, t0, p, ne, dcy, wr, b, r, c, t;
    int ec [3]; int et [3]; string rq [3];
    {wr, b, r, c, t} = {31'd0, v[VW-1], 30'd0, v[VW-2 -: 2], 24'd0, v[TAG_W+COL_W +: ROW_W],
                        26'd0, v[TAG_W +: COL_W], 28'd0, v[TAG_W-1:0]};
    n_log = 0; n_done = 0;
    @(negedge clk);
    k = cyc;
    req_valid = 1; req_wr = wr[0]; req_bank = b[1:0]; req_row = r[ROW_W-1:0];
    req_col = c[COL_W-1:0]; req_tag = t[TAG_W-1:0];
    t0 = (k + 1 > earliest) ? k + 1 : earliest;
    if (bopen[b] && brow[b] == r) begin
      ne = 1; ec[0] = wr ? C_WR : C_RD; et[0] = t0; rq[0] = "R3";
    end else if (!bopen[b]) begin
      ne = 2; ec[0] = C_ACT; et[0] = t0; rq[0] = "R2";
      ec[1] = wr ? C_WR : C_RD; et[1] = t0 + 8; rq[1] = "R2";
    end else begin
      p = (t0 > lastpre + TPG) ? t0 : lastpre + TPG;
      ne = 3; ec[0] = C_PRE; et[0] = p; rq[0] = (p > t0) ? "R5" : "R4";
      ec[1] = C_ACT; et[1] = p + 8; rq[1] = "R4";
      ec[2] = wr ? C_WR : C_RD; et[2] = p + 16; rq[2] = "R4";
      lastpre = p;
    end
    dcy = et[ne-1] + 4;
    bopen[b] = 1; brow[b] = r;
    @(negedge clk); req_valid = 0;
    while (n_done < 1) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(n_log == ne, rq[ne-1], "command count", n_log, ne);
    for (int j = 0; j < ne && j < n_log; j++) begin
      chk(lg_code[j] == ec[j], rq[j], "command code", lg_code[j], ec[j]);
      chk(lg_cyc[j] == et[j], rq[j], "command cycle", lg_cyc[j], et[j]);
      chk(lg_bank[j] == b, rq[j], "command bank", lg_bank[j], b);
      if (ec[j] == C_ACT) chk(lg_row[j] == r, rq[j], "activate row", lg_row[j], r);
      if (ec[j] == C_RD || ec[j] == C_WR) chk(lg_col[j] == c, rq[j], "data column", lg_col[j], c);
    end
    chk(dn_cyc[0] == dcy, "R6", "done cycle", dn_cyc[0], dcy);
    chk(dn_tag[0] == t, "R6", "done tag", dn_tag[0], t);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin bopen[i] = 0; brow[i] = 0; end
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    chk(cmd_valid == 0, "R1", "cmd_valid in reset", cmd_valid, 0);
    chk(done_valid == 0, "R1", "done_valid in reset", done_valid, 0);
    chk(req_ready == 1, "R1", "req_ready in reset", req_ready, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && cmd_valid == 0, "R1", "idle after reset", cmd_valid, 0);

    // table walk: R1 R2 R3 R4 R5 R6, R10 (bank 0 hit after bank 1 opened)
    for (int i = 0; i < 10; i++) run_ref(VEC[i], 0);

    // R7: queue depth and order, all hits to bank 0 row 5
    n_log = 0; n_done = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_valid = 1; req_wr = i[0]; req_bank = 0; req_row = 5; req_col = 6'(i);
      req_tag = 4'(10 + i);
    end
    @(negedge clk); req_valid = 0;
    chk(req_ready == 0, "R7", "ready with 4 held", req_ready, 0);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_wr = 0; req_tag = 4'(14); req_col = 6'(4);
    @(negedge clk); req_valid = 0;
    while (n_done < 5) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++)
      chk(dn_tag[i] == 10 + i, "R7", "completion order", dn_tag[i], 10 + i);
    chk(n_log == 5, "R7", "hit commands only", n_log, 5);

    // R8 / R9: refresh
    n_ref = 0; n_prea = 0;
    while (n_ref < 2) @(negedge clk);
    chk(ref_at[0] - prea_at[0] == 8, "R8", "PREA to REF", ref_at[0] - prea_at[0], 8);
    chk(ref_at[1] - ref_at[0] == PERIOD, "R8", "refresh period", ref_at[1] - ref_at[0], PERIOD);
    lastpre = prea_at[1];
    for (int i = 0; i < 4; i++) bopen[i] = 0;
    // bank 1 had row 2 open: expect ACTIVATE, not before REF + 64
    run_ref(mk(0, 1, 2, 11, 3), ref_at[1] + 64);
    chk(lg_code[0] == C_ACT, "R9", "activate after refresh", lg_code[0], C_ACT);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule